// File: doc/BRIEF.md
# Register-Stack RAM with Edge-Captured Output

This block is a small read/write store of sixteen 4-bit words with a 4-bit output register in front of tri-state data pins. The array is written by a transparent, level-sensitive path: while chip select, write enable and the clock pin are all low, the word at the addressed location follows the data inputs. The output register changes only on a rising clock edge. It holds its value between edges, so new data can enter the array without disturbing what the pins show.

On a rising edge with the block selected, the register takes the addressed word when write enable is high. When write enable is low it takes the data inputs, so a write also appears on the outputs. When the block is deselected, the edge leaves the register alone. A separate active-low output enable either drives the register onto the pins or releases them to high impedance. All pins are plain control and data lines with no handshake, because the block has no back-pressure. Contents are undefined at power-up until each location is written.

Top module: `regstack_ram`

## Requirements
- R1: The array stores 16 words of 4 bits. Location k is selected by address value k, and a read of location k returns the last word written there.
- R2: A write changes only the addressed location. Every other location keeps its contents.
- R3: While chip select, write enable and the clock are all low, later changes on the data inputs pass into the selected location. The value present just before any of the three rises is the one kept.
- R4: On a rising clock edge with chip select low and write enable high, the output register loads the word stored at the addressed location.
- R5: On a rising clock edge with chip select low and write enable low, the output register loads the data inputs (write-through).
- R6: With output enable high, all four outputs are high-impedance. With output enable low, they show the output register.
- R7: With chip select high, no location is written and a rising clock edge leaves the output register unchanged.
- R8: While a write is open during the low clock phase, the outputs keep the value captured at the previous rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock pin. Its low phase opens the array write; its rising edge loads the output register |
| cs_n_i | input | 1 | Chip select, active low |
| we_n_i | input | 1 | Write enable, active low |
| oe_n_i | input | 1 | Output enable, active low |
| addr_i | input | 4 | Word address |
| din_i | input | 4 | Data inputs |
| q_o | output | 4 | Tri-state data outputs |

## Verification
The assertions assume that address, data, chip select and write enable settle while the clock is high and stay fixed up to the next rising edge. The data inputs are the one exception: they may still change during the low phase of a write. Under that assumption the addressed word equals the data inputs at every rising edge of a write, and the register captures can be compared with the values sampled at that edge. The stimulus changes the controls shortly after each rising edge. Only one directed test moves the data inside the low phase, and it leaves the final value in place before the clock rises.

// File: rtl/rsr_pkg.sv
`timescale 1ns/1ps
package rsr_pkg;
  localparam int unsigned DATA_W_DEF = 4;
  localparam int unsigned ADDR_W_DEF = 4;
endpackage

// File: rtl/rsr_wr_decode.sv
`timescale 1ns/1ps
module rsr_wr_decode #(
  parameter int unsigned ADDR_W = 4,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic              open_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [DEPTH-1:0]  sel_o
);
  always_comb begin
    sel_o = '0;
    if (open_i) sel_o[addr_i] = 1'b1;
  end
endmodule

// File: rtl/rsr_latch_bank.sv
`timescale 1ns/1ps
module rsr_latch_bank #(
  parameter int unsigned DATA_W = 4,
  parameter int unsigned ADDR_W = 4,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic [DEPTH-1:0]  sel_i,
  input  logic [DATA_W-1:0] din_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [DATA_W-1:0] rd_word_o
);
  logic [DEPTH-1:0][DATA_W-1:0] bank;

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    logic [DATA_W-1:0] word_q;
    // transparent while this word is selected and the write window is open
    always_latch begin
      if (sel_i[i]) word_q <= din_i;
    end
    assign bank[i] = word_q;
  end

  assign rd_word_o = bank[addr_i];
endmodule

// File: rtl/rsr_out_reg.sv
`timescale 1ns/1ps
module rsr_out_reg #(
  parameter int unsigned DATA_W = 4
) (
  input  logic              clk_i,
  input  logic              cs_n_i,
  input  logic              we_n_i,
  input  logic [DATA_W-1:0] rd_word_i,
  input  logic [DATA_W-1:0] din_i,
  output logic [DATA_W-1:0] oreg_o
);
  logic [DATA_W-1:0] next_val;

  // a write passes its own data through; a read takes the stored word
  assign next_val = we_n_i ? rd_word_i : din_i;

  always_ff @(posedge clk_i) begin
    if (!cs_n_i) oreg_o <= next_val;
  end
endmodule

// File: rtl/regstack_ram.sv
`timescale 1ns/1ps
module regstack_ram
  import rsr_pkg::*;
#(
  parameter int unsigned DATA_W = DATA_W_DEF,
  parameter int unsigned ADDR_W = ADDR_W_DEF,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              cs_n_i,
  input  logic              we_n_i,
  input  logic              oe_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] din_i,
  output logic [DATA_W-1:0] q_o
);
  logic              wr_open;
  logic [DEPTH-1:0]  wr_sel;
  logic [DATA_W-1:0] rd_word;
  logic [DATA_W-1:0] oreg;

  assign wr_open = ~clk_i & ~cs_n_i & ~we_n_i;

  rsr_wr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .open_i (wr_open),
    .addr_i (addr_i),
    .sel_o  (wr_sel)
  );

  rsr_latch_bank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_bank (
    .sel_i     (wr_sel),
    .din_i     (din_i),
    .addr_i    (addr_i),
    .rd_word_o (rd_word)
  );

  rsr_out_reg #(.DATA_W(DATA_W)) u_oreg (
    .clk_i     (clk_i),
    .cs_n_i    (cs_n_i),
    .we_n_i    (we_n_i),
    .rd_word_i (rd_word),
    .din_i     (din_i),
    .oreg_o    (oreg)
  );

  assign q_o = oe_n_i ? 'z : oreg;
endmodule

// File: rtl/rsr_checker.sv
`timescale 1ns/1ps
module rsr_checker #(
  parameter int unsigned DATA_W = 4
) (
  input logic              clk_i,
  input logic              cs_n_i,
  input logic              we_n_i,
  input logic [DATA_W-1:0] din_i,
  input logic [DATA_W-1:0] rd_word_i,
  input logic [DATA_W-1:0] oreg_i
);
  logic armed = 1'b0;
  always_ff @(posedge clk_i) armed <= 1'b1;

  // R3: after the low-phase write, the addressed word holds the final data
  p_wrthru_array_r3: assert property (@(posedge clk_i) disable iff (!armed)
    (!cs_n_i && !we_n_i) |-> (rd_word_i == din_i));

  // R4: a read edge loads the addressed word
  p_read_capture_r4: assert property (@(posedge clk_i) disable iff (!armed)
    (!cs_n_i && we_n_i) |=> (oreg_i == $past(rd_word_i)));

  // R5: a write edge loads the data inputs
  p_write_capture_r5: assert property (@(posedge clk_i) disable iff (!armed)
    (!cs_n_i && !we_n_i) |=> (oreg_i == $past(din_i)));

  // R7: deselected edge leaves the register unchanged
  p_deselect_hold_r7: assert property (@(posedge clk_i) disable iff (!armed)
    cs_n_i |=> (oreg_i == $past(oreg_i)));
endmodule

bind regstack_ram rsr_checker #(.DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .cs_n_i    (cs_n_i),
  .we_n_i    (we_n_i),
  .din_i     (din_i),
  .rd_word_i (rd_word),
  .oreg_i    (oreg)
);

// File: tb/sim_regstack_ram.sv
`timescale 1ns/1ps
module sim_regstack_ram;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [3:0] addr = '0, din = '0;
  wire  [3:0] q_w;

  int n_chk = 0;
  int n_bad = 0;

  logic [3:0] ref_mem [16];
  logic [3:0] ref_q;

  always #10 clk = ~clk; // 50 MHz

  // released outputs read back as all ones through the pull-ups
  for (genvar i = 0; i < 4; i++) begin : g_pu
    pullup (q_w[i]);
  end

  regstack_ram u0 (
    .clk_i  (clk),
    .cs_n_i (cs_n),
    .we_n_i (we_n),
    .oe_n_i (oe_n),
    .addr_i (addr),
    .din_i  (din),
    .q_o    (q_w)
  );

  // {cs_n, we_n, oe_n, addr, din}
  localparam logic [10:0] VEC [12] = '{
    {3'b010, 4'h3, 4'h0},  // R4 read
    {3'b000, 4'h3, 4'h6},  // R5 write-through
    {3'b010, 4'h3, 4'h0},  // R1 read back new word
    {3'b110, 4'h7, 4'h0},  // R7 hold
    {3'b100, 4'h7, 4'h1},  // R7 no write while deselected
    {3'b011, 4'h9, 4'h0},  // R6 float
    {3'b010, 4'h7, 4'h0},  // R7 location 7 untouched
    {3'b000, 4'hF, 4'h0},  // R5 write zero
    {3'b010, 4'h0, 4'h0},  // R2 neighbour intact
    {3'b010, 4'hF, 4'h0},  // R4 read zero
    {3'b001, 4'h5, 4'hC},  // R5 write while disabled
    {3'b010, 4'h5, 4'h0}   // R1 read it
  };

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: q=%h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] exp_pins(input logic oe);
    return oe ? 4'hF : ref_q;
  endfunction

  // drive now (just after a rising edge), then sample 5 ns after the next one
  task automatic step(input logic c, input logic w, input logic o,
                      input logic [3:0] a, input logic [3:0] d, input string tag);
    cs_n = c; we_n = w; oe_n = o; addr = a; din = d;
    if (!c && !w) ref_mem[a] = d;
    if (!c) ref_q = w ? ref_mem[a] : d;
    @(posedge clk); #5;
    check(tag, q_w, exp_pins(o));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    #5;
    rst = 1'b0;
    // reset state: deselected and disabled, pins float (R6)
    check("R6 reset float", q_w, 4'hF);

    // R5: fill every location, each write shows through
    for (int k = 0; k < 16; k++)
      step(1'b0, 1'b0, 1'b0, 4'(k), 4'(k) ^ 4'hA, "R5 init write");
    // R1/R4: read every location
    for (int k = 0; k < 16; k++)
      step(1'b0, 1'b1, 1'b0, 4'(k), 4'h0, "R1 R4 read");

    for (int v = 0; v < 12; v++)
      step(VEC[v][10], VEC[v][9], VEC[v][8], VEC[v][7:4], VEC[v][3:0], "R2 R7 table");

    // R6: register non-all-ones, disable outputs
    step(1'b0, 1'b1, 1'b0, 4'h2, 4'h0, "R4 read before float");
    step(1'b1, 1'b1, 1'b1, 4'h2, 4'h0, "R6 float");
    step(1'b1, 1'b1, 1'b0, 4'h2, 4'h0, "R6 enable again");

    // R8 and R3: data changes inside the low phase of a write
    cs_n = 1'b0; we_n = 1'b0; oe_n = 1'b0; addr = 4'h4; din = 4'h3;
    #7;
    check("R8 hold during write", q_w, ref_q);
    din = 4'h9;
    ref_mem[4] = 4'h9;
    ref_q = 4'h9;
    @(posedge clk); #5;
    check("R3 last data kept", q_w, ref_q);
    step(1'b0, 1'b1, 1'b0, 4'h8, 4'h0, "R2 other location");
    step(1'b0, 1'b1, 1'b0, 4'h4, 4'h0, "R3 read back");

    // R2: final sweep of the whole array
    for (int k = 0; k < 16; k++)
      step(1'b0, 1'b1, 1'b0, 4'(k), 4'h0, "R2 sweep");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule